// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block keeps the sticky event status of a serial bus controller and turns it into one level interrupt line and two DMA request lines. The bus engine raises events through one-cycle set pulses, one per status bit. Each pulse sets its status bit, and the bit stays set until software takes it away. A five-bit enable mask selects which of the low status bits can drive the interrupt.

Software reaches the block through a 16-bit register port with four registers: enable mask, status, vector and buffer configuration. A read of the vector register returns the number of the lowest pending, enabled source, counted from 1, and clears that one source in the same access. In the buffer-configuration register, setting a direction's DMA enable routes that direction's ready status bit to its DMA request line. The same write masks that direction's ready interrupt, so DMA and the interrupt do not both service the same event.

Top module: `irq_vector_unit`

## Requirements
- R1: `irqOut` is high exactly when (status AND enable mask) is nonzero. It is registered and changes on the same clock edge as the status and mask it reflects.
- R2: A write to the enable-mask register (address 0) keeps only write-data bits 4:0. A read returns those five bits with all upper bits zero. Bit 1 is NACK, bit 2 is access-ready, bit 3 is receive-ready and bit 4 is transmit-ready.
- R3: A read of the vector register (address 2) returns, combinationally in the read cycle, k+1 for the lowest k where status[k] and mask[k] are both set. It returns 0 when there is no such bit.
- R4: A vector read that returns a nonzero value clears that one status bit at the clock edge ending the read. A read that returns 0 changes nothing.
- R5: A write to the buffer-configuration register (address 3) keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). A read returns them in those same positions, with every other bit zero.
- R6: `rxDmaReq` is high exactly when receive DMA is enabled and status bit 3 is set. `txDmaReq` is high exactly when transmit DMA is enabled and status bit 4 is set. Both are registered like `irqOut`.
- R7: A buffer-configuration write with bit 15 set clears enable-mask bit 3. The same write with bit 7 set clears enable-mask bit 4. The other mask bits are kept.
- R8: A status read (address 1) returns the stored status with bit 12 replaced by the live `busBusy` input. Stored status bit 12 is never set by an event pulse.
- R9: Writes to the status and vector registers change no state.
- R10: Status bits are sticky, and only a vector read clears them. If a set pulse and a vector-read clear land in the same cycle, the cleared bit ends at 0 and every other pulsed bit ends at 1.
- R11: Reset (active low, synchronous) sets status, mask, DMA enables and all three outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| evtSet | input | 16 | One set pulse per status bit |
| busBusy | input | 1 | Live bus-busy flag shown in status bit 12 |
| regAddr | input | 2 | Register select: 0 mask, 1 status, 2 vector, 3 buffer config |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdEn | input | 1 | Register read strobe (the vector read clears a source) |
| regRdData | output | 16 | Combinational read data, zero when no read |
| irqOut | output | 1 | Interrupt line |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |

## Verification
On every cycle the assertions check three things: the interrupt and DMA lines agree with the stored status, mask and enables; no status bit is lost without a vector read; and the stored busy bit stays zero. They also check that each buffer-configuration write masks the ready interrupt it should, and that each nonzero vector read leaves its source clear. Only the bench's scenarios can show the encoder's choice among several pending sources and the exact read-back layout of each register. They also show that writes to read-only registers leave status untouched, and how a same-cycle set and clear resolve for neighbouring bits.

// File: rtl/isv_pkg.sv
package isv_pkg;
  localparam int DATA_W   = 16;
  localparam int MASK_W   = 5;
  localparam int ADDR_W   = 2;
  localparam int BUSY_BIT = 12;
  localparam int RX_BIT   = 3;
  localparam int TX_BIT   = 4;
  localparam int RXEN_BIT = 15;
  localparam int TXEN_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MASK = 2'd0,
    SEL_STAT = 2'd1,
    SEL_VEC  = 2'd2,
    SEL_BUF  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrMask;
    logic    wrBuf;
    logic    rdVec;
    logic    rdActive;
    regSel_e rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/isv_ctrl.sv
module isv_ctrl
  import isv_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobes_t      strobes
);
  regSel_e sel;

  always_comb begin
    sel = regSel_e'(regAddr);
    strobes          = '0;
    strobes.rdSel    = sel;
    strobes.rdActive = regRdEn;
    strobes.rdVec    = regRdEn && (sel == SEL_VEC);
    // status and vector are read-only: no write strobe exists for them
    strobes.wrMask   = regWrEn && (sel == SEL_MASK);
    strobes.wrBuf    = regWrEn && (sel == SEL_BUF);
  end
endmodule

// File: rtl/isv_datapath.sv
module isv_datapath
  import isv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] evtSet,
  input  logic              busBusy,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] statusQ,
  output logic [MASK_W-1:0] maskQ,
  output logic              rxEnQ,
  output logic              txEnQ,
  output logic              irqQ,
  output logic              rxReqQ,
  output logic              txReqQ
);
  localparam int VEC_W = $clog2(MASK_W + 1);
  localparam logic [DATA_W-1:0] BUSY_ONE = DATA_W'(1) << BUSY_BIT;

  logic [MASK_W-1:0] pend;
  logic [VEC_W-1:0]  vecIdx;
  logic [MASK_W-1:0] clrLow;
  logic [DATA_W-1:0] clrVec;
  logic [DATA_W-1:0] statusD;
  logic [MASK_W-1:0] maskD;
  logic              rxEnD, txEnD;

  assign pend = statusQ[MASK_W-1:0] & maskQ;

  // lowest-index pending source wins; scan from the top so low bits override
  always_comb begin
    vecIdx = '0;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (pend[i]) vecIdx = VEC_W'(i + 1);
    end
  end

  genvar g;
  generate
    for (g = 0; g < MASK_W; g++) begin : g_clr
      assign clrLow[g] = strobes.rdVec && (vecIdx == VEC_W'(g + 1));
    end
  endgenerate

  assign clrVec = {{(DATA_W - MASK_W){1'b0}}, clrLow};

  always_comb begin
    // the cleared bit loses to nothing; other pulses always land
    statusD = (statusQ | (evtSet & ~BUSY_ONE)) & ~clrVec;
    maskD   = maskQ;
    rxEnD   = rxEnQ;
    txEnD   = txEnQ;
    if (strobes.wrMask) maskD = wrData[MASK_W-1:0];
    if (strobes.wrBuf) begin
      rxEnD = wrData[RXEN_BIT];
      txEnD = wrData[TXEN_BIT];
      if (wrData[RXEN_BIT]) maskD[RX_BIT] = 1'b0;
      if (wrData[TXEN_BIT]) maskD[TX_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      rxEnQ   <= 1'b0;
      txEnQ   <= 1'b0;
      irqQ    <= 1'b0;
      rxReqQ  <= 1'b0;
      txReqQ  <= 1'b0;
    end else begin
      statusQ <= statusD;
      maskQ   <= maskD;
      rxEnQ   <= rxEnD;
      txEnQ   <= txEnD;
      irqQ    <= |(statusD[MASK_W-1:0] & maskD);
      rxReqQ  <= rxEnD & statusD[RX_BIT];
      txReqQ  <= txEnD & statusD[TX_BIT];
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdActive) begin
      unique case (strobes.rdSel)
        SEL_MASK: rdData = DATA_W'(maskQ);
        SEL_STAT: rdData = (statusQ & ~BUSY_ONE) | (busBusy ? BUSY_ONE : '0);
        SEL_VEC:  rdData = DATA_W'(vecIdx);
        SEL_BUF: begin
          rdData[RXEN_BIT] = rxEnQ;
          rdData[TXEN_BIT] = txEnQ;
        end
        default:  rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import isv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] evtSet,
  input  logic              busBusy,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq
);
  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] statusQ;
  logic [MASK_W-1:0] maskQ;
  logic              rxEnQ, txEnQ;

  isv_ctrl ctrl_i (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  isv_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .evtSet  (evtSet),
    .busBusy (busBusy),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .rxEnQ   (rxEnQ),
    .txEnQ   (txEnQ),
    .irqQ    (irqOut),
    .rxReqQ  (rxDmaReq),
    .txReqQ  (txDmaReq)
  );
endmodule

// File: rtl/isv_checker.sv
module isv_checker
  import isv_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic              regRdEn,
  input logic [DATA_W-1:0] regRdData,
  input logic              irqOut,
  input logic              rxDmaReq,
  input logic              txDmaReq,
  input logic [DATA_W-1:0] statusQ,
  input logic [MASK_W-1:0] maskQ,
  input logic              rxEnQ,
  input logic              txEnQ
);
  logic vecRead;
  assign vecRead = regRdEn && (regAddr == 2'd2);

  p_irq_match_r1: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(statusQ[MASK_W-1:0] & maskQ));

  p_rx_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxDmaReq == (rxEnQ && statusQ[RX_BIT]));

  p_tx_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq == (txEnQ && statusQ[TX_BIT]));

  p_buf_rx_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd3 && regWrData[RXEN_BIT]) |=> !maskQ[RX_BIT]);

  p_buf_tx_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd3 && regWrData[TXEN_BIT]) |=> !maskQ[TX_BIT]);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    !vecRead |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  p_vec_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (vecRead && regRdData != '0) |=>
      (((statusQ >> ($past(regRdData[3:0]) - 4'd1)) & DATA_W'(1)) == '0));

  p_busy_unstored_r8: assert property (@(posedge clk) disable iff (!rstN)
    !statusQ[BUSY_BIT]);
endmodule

bind irq_vector_unit isv_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdEn   (regRdEn),
  .regRdData (regRdData),
  .irqOut    (irqOut),
  .rxDmaReq  (rxDmaReq),
  .txDmaReq  (txDmaReq),
  .statusQ   (statusQ),
  .maskQ     (maskQ),
  .rxEnQ     (rxEnQ),
  .txEnQ     (txEnQ)
);

// File: tb/irq_vector_unit_tb.sv
module irq_vector_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] evtSet = '0;
  logic        busBusy = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [15:0] regRdData;
  logic        irqOut, rxDmaReq, txDmaReq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of the architectural state
  logic [15:0] mStat = '0;
  logic [4:0]  mMask = '0;
  logic        mRx = 1'b0, mTx = 1'b0;

  always #4 clk = ~clk;

  irq_vector_unit dut_i (
    .clk(clk), .rstN(rstN), .evtSet(evtSet), .busBusy(busBusy),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData),
    .irqOut(irqOut), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] vecOf(input logic [15:0] st, input logic [4:0] mk);
    logic [4:0] p = st[4:0] & mk;
    for (int i = 0; i < 5; i++) if (p[i]) return 16'(i + 1);
    return 16'd0;
  endfunction

  function automatic logic [15:0] readOf(input logic [1:0] a);
    case (a)
      2'd0: return {11'd0, mMask};
      2'd1: return (mStat & ~16'h1000) | (busBusy ? 16'h1000 : 16'h0);
      2'd2: return vecOf(mStat, mMask);
      default: return {mRx, 7'd0, mTx, 7'd0};
    endcase
  endfunction

  function automatic string rdTag(input logic [1:0] a);
    case (a)
      2'd0: return "R2";
      2'd1: return "R8";
      2'd2: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic checkOutputs();
    check({15'd0, irqOut}, {15'd0, |(mStat[4:0] & mMask)}, "R1 irq");
    check({15'd0, rxDmaReq}, {15'd0, mRx & mStat[3]}, "R6 rx");
    check({15'd0, txDmaReq}, {15'd0, mTx & mStat[4]}, "R6 tx");
  endtask

  // one bus cycle: drive at negedge, check reads, advance model at posedge
  task automatic step(input bit wr, input bit rd, input logic [1:0] a,
                      input logic [15:0] wd, input logic [15:0] ev,
                      input bit busy, input string tag);
    logic [15:0] nStat, clr;
    logic [4:0]  nMask;
    logic        nRx, nTx;
    logic [15:0] v;
    @(negedge clk);
    checkOutputs();
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = wd;
    evtSet = ev; busBusy = busy;
    #1;
    check(regRdData, rd ? readOf(a) : 16'h0, (tag != "") ? tag : rdTag(a));
    v = vecOf(mStat, mMask);
    clr = (rd && a == 2'd2 && v != 0) ? (16'd1 << (v - 1)) : 16'd0;
    nStat = (mStat | (ev & ~16'h1000)) & ~clr;
    nMask = mMask; nRx = mRx; nTx = mTx;
    if (wr && a == 2'd0) nMask = wd[4:0];
    if (wr && a == 2'd3) begin
      nRx = wd[15]; nTx = wd[7];
      if (wd[15]) nMask[3] = 1'b0;
      if (wd[7])  nMask[4] = 1'b0;
    end
    @(posedge clk);
    mStat = nStat; mMask = nMask; mRx = nRx; mTx = nTx;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finish();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: outputs and state zero after reset
    check({13'd0, irqOut, rxDmaReq, txDmaReq}, 16'd0, "R11 outputs");
    rstN = 1'b1;
    step(0, 1, 2'd0, 0, 0, 0, "R11 mask");
    step(0, 1, 2'd1, 0, 0, 0, "R11 status");
    step(0, 1, 2'd3, 0, 0, 0, "R11 buf");
    // R2: mask keeps low five bits
    step(1, 0, 2'd0, 16'hFFFF, 0, 0, "");
    step(0, 1, 2'd0, 0, 0, 0, "R2 mask width");
    // R3/R4: two sources pending, lowest reported first and cleared
    step(0, 0, 2'd0, 0, 16'h000A, 0, "");
    step(0, 1, 2'd2, 0, 0, 0, "R3 vec lowest");
    step(0, 1, 2'd2, 0, 0, 0, "R4 after clear");
    step(0, 1, 2'd2, 0, 0, 0, "R4 empty vec");
    step(0, 1, 2'd1, 0, 0, 0, "R4 status after empty read");
    // R8: pulse on busy bit is not stored, live flag shown
    step(0, 0, 2'd0, 0, 16'h1000, 0, "");
    step(0, 1, 2'd1, 0, 0, 1, "R8 busy live");
    step(0, 1, 2'd1, 0, 0, 0, "R8 busy unstored");
    // R9: writes to status and vector ignored
    step(0, 0, 2'd0, 0, 16'h0020, 0, "");
    step(1, 0, 2'd1, 16'hFFFF, 0, 0, "");
    step(1, 0, 2'd2, 16'h0000, 0, 0, "");
    step(0, 1, 2'd1, 0, 0, 0, "R9 status unchanged");
    // R10: set and clear in the same cycle
    step(0, 0, 2'd0, 0, 16'h0014, 0, "");
    step(0, 1, 2'd2, 0, 16'h0005, 0, "R10 vec during set");
    step(0, 1, 2'd1, 0, 0, 0, "R10 status after collision");
    // R5/R7/R6: DMA enables mask ready interrupts and route requests
    step(1, 0, 2'd0, 16'h001F, 0, 0, "");
    step(1, 0, 2'd3, 16'hFFFF, 0, 0, "");
    step(0, 1, 2'd3, 0, 0, 0, "R5 buf bits");
    step(0, 1, 2'd0, 0, 0, 0, "R7 mask after buf");
    step(0, 0, 2'd0, 0, 16'h0018, 0, "");
    step(0, 0, 2'd0, 0, 0, 0, "");
    step(1, 0, 2'd3, 16'h0080, 0, 0, "");
    step(0, 1, 2'd0, 0, 0, 0, "R7 partial");
    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom % 4;
      logic [15:0] ev = 16'($urandom & $urandom & $urandom);
      step(op == 1 || op == 3, op >= 2, 2'($urandom % 4), 16'($urandom),
           ev, 1'($urandom), "");
    end
    @(negedge clk);
    checkOutputs();
    finish();
  end
endmodule